// File: doc/BRIEF.md
# Atomic Read-Modify-Write Sequencer

This block runs indivisible read-modify-write operations for a virtual machine's execution core against one single-port synchronous memory. A request carries a base register value, a signed 16-bit displacement, a source register value, the R0 register value, a 2-bit access-size code and an 8-bit operation code. The block reads the addressed location and computes the new value. It writes that value back unless the operation says not to, then returns the updated source and R0 register values along with an error flag.

Plain loads and stores from the core share the memory port. They pass straight through while the sequencer is idle and are stalled for as long as an atomic operation holds the port. Each legal operation walks the states IDLE, READ, MODIFY, WRITE, DONE and then returns to IDLE. A request with an illegal size or operation code takes the transition IDLE to DONE, flags an error and never touches the memory.

Top module: `amo_seq_unit`

## Requirements
- R1: The size code `req_size` 2'b00 selects a 32-bit word and 2'b11 a 64-bit double word. Codes 2'b01 and 2'b10 (half word, byte) are rejected: `done` with `err` high on the cycle after acceptance, and no memory access.
- R2: The memory address is `req_base` plus `req_offset` sign-extended to 64 bits. The read and the write of one operation use the same address.
- R3: Op codes 8'h00 add, 8'h40 OR, 8'h50 AND and 8'hA0 XOR store old-value-op-source. Each may carry the fetch bit 8'h01. A 32-bit operation works on the low 32 bits of the source and wraps at 32 bits.
- R4: With the fetch bit set, `res_src` returns the memory value from before the operation, zero-extended for 32-bit accesses. Without it, `res_src` equals `req_src`.
- R5: Op code 8'hE1 stores the source value and returns the old value in `res_src`.
- R6: Op code 8'hF1 compares the old value with R0 at the access width. It stores the source only on a match, leaves `res_src` equal to `req_src`, and always returns the zero-extended old value in `res_r0`. Every other operation returns `res_r0` equal to `req_r0`.
- R7: Any other op code (including 8'hE0 and 8'hF0) completes with `err` high, no memory access and both results unchanged.
- R8: A request is accepted when `req_valid` is high and `busy` is low. The read is issued on the next cycle, the write two cycles after the read, and `done` pulses for one cycle on the cycle after the write slot. `busy` is high from the cycle after acceptance through the `done` cycle.
- R9: While idle, the load/store port drives the memory port directly and `ls_rdata` follows `mem_rdata`. While `busy` is high, `ls_stall` is high and load/store requests do not reach the memory.
- R10: A 32-bit access drives `mem_dword` low, and its write data has the upper 32 bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic request present |
| req_base | input | 64 | Base register value |
| req_offset | input | 16 | Signed displacement |
| req_src | input | 64 | Source register value |
| req_r0 | input | 64 | R0 register value |
| req_size | input | 2 | Size code: 00 word, 11 double word |
| req_imm | input | 8 | Operation code |
| busy | output | 1 | Atomic operation owns the port |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completed operation was rejected |
| res_src | output | 64 | Updated source register value |
| res_r0 | output | 64 | Updated R0 value |
| ls_valid | input | 1 | Load/store request |
| ls_we | input | 1 | Load/store is a write |
| ls_dword | input | 1 | Load/store width is 64 bits |
| ls_addr | input | 64 | Load/store byte address |
| ls_wdata | input | 64 | Load/store write data |
| ls_stall | output | 1 | Load/store held off |
| ls_rdata | output | 64 | Load data |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Memory write enable |
| mem_dword | output | 1 | Access width is 64 bits (else 32, right-aligned) |
| mem_addr | output | 64 | Memory byte address |
| mem_wdata | output | 64 | Memory write data |
| mem_rdata | input | 64 | Memory read data, valid the cycle after a read |

## Verification
The hardest case to reach is a load/store that collides with an atomic operation in flight, so that a stalled store would corrupt the locked location if the stall failed. The bench therefore drives a store of junk data to the same address on many random operations while `busy` is high, and then compares the whole memory entry with its own prediction. A second hard case is a compare-exchange that matches, which random values almost never produce. Half of the compare-exchange vectors copy the current memory value into R0, and word-sized ones fill R0's upper half with garbage to test the width of the comparison.

// File: rtl/amo_pkg.sv
package amo_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_MODIFY,
        ST_WRITE,
        ST_DONE
    } amo_state_e;

    typedef enum logic [2:0] {
        OP_ADD,
        OP_OR,
        OP_AND,
        OP_XOR,
        OP_SWAP,
        OP_CAS
    } amo_op_e;

    typedef struct packed {
        amo_op_e op;
        logic    fetch;
        logic    legal;
        logic    dword;
    } amo_dec_t;

    localparam logic [1:0] SZ_WORD  = 2'b00;
    localparam logic [1:0] SZ_DWORD = 2'b11;

endpackage

// File: rtl/amo_decode.sv
module amo_decode
    import amo_pkg::*;
#(
    parameter int IMMW = 8
) (
    input  logic [IMMW-1:0] imm,
    input  logic [1:0]      size,
    output amo_dec_t        dec
);
    localparam int HI = IMMW - 1;

    logic       size_ok;
    logic       op_ok;
    logic       low_zero;
    amo_op_e    op;

    always_comb begin
        size_ok  = (size == SZ_WORD) || (size == SZ_DWORD);
        low_zero = (imm[3:1] == 3'b000) && (imm[HI:8] == '0 || IMMW == 8);
        op       = OP_ADD;
        op_ok    = 1'b0;
        unique case (imm[7:4])
            4'h0: begin op = OP_ADD;  op_ok = 1'b1;   end
            4'h4: begin op = OP_OR;   op_ok = 1'b1;   end
            4'h5: begin op = OP_AND;  op_ok = 1'b1;   end
            4'hA: begin op = OP_XOR;  op_ok = 1'b1;   end
            4'hE: begin op = OP_SWAP; op_ok = imm[0]; end
            4'hF: begin op = OP_CAS;  op_ok = imm[0]; end
            default: begin op = OP_ADD; op_ok = 1'b0; end
        endcase
        dec.op    = op;
        dec.fetch = imm[0] && (op != OP_CAS);
        dec.legal = size_ok && op_ok && low_zero;
        dec.dword = (size == SZ_DWORD);
    end

endmodule

// File: rtl/amo_alu.sv
module amo_alu
    import amo_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  amo_dec_t        dec,
    input  logic [XLEN-1:0] old_raw,
    input  logic [XLEN-1:0] src,
    input  logic [XLEN-1:0] r0,
    output logic [XLEN-1:0] new_val,
    output logic            do_write,
    output logic [XLEN-1:0] src_out,
    output logic [XLEN-1:0] r0_out
);
    localparam int HALF = XLEN / 2;

    logic [XLEN-1:0] old_n;
    logic [XLEN-1:0] src_n;
    logic [XLEN-1:0] r0_n;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] raw;
    logic            match;

    function automatic logic [XLEN-1:0] narrow(input logic [XLEN-1:0] v, input logic dw);
        return dw ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    always_comb begin
        old_n = narrow(old_raw, dec.dword);
        src_n = narrow(src, dec.dword);
        r0_n  = narrow(r0, dec.dword);
        sum   = old_n + src_n;
        match = (old_n == r0_n);
        raw   = src_n;
        unique case (dec.op)
            OP_ADD:  raw = sum;
            OP_OR:   raw = old_n | src_n;
            OP_AND:  raw = old_n & src_n;
            OP_XOR:  raw = old_n ^ src_n;
            OP_SWAP: raw = src_n;
            OP_CAS:  raw = src_n;
            default: raw = src_n;
        endcase
        new_val  = narrow(raw, dec.dword);
        do_write = (dec.op != OP_CAS) || match;
        src_out  = dec.fetch ? old_n : src;
        r0_out   = (dec.op == OP_CAS) ? old_n : r0;
    end

endmodule

// File: rtl/amo_seq_unit.sv
module amo_seq_unit
    import amo_pkg::*;
#(
    parameter int XLEN = 64,
    parameter int AW   = 64,
    parameter int OFFW = 16,
    parameter int IMMW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_base,
    input  logic [OFFW-1:0] req_offset,
    input  logic [XLEN-1:0] req_src,
    input  logic [XLEN-1:0] req_r0,
    input  logic [1:0]      req_size,
    input  logic [IMMW-1:0] req_imm,
    output logic            busy,
    output logic            done,
    output logic            err,
    output logic [XLEN-1:0] res_src,
    output logic [XLEN-1:0] res_r0,
    input  logic            ls_valid,
    input  logic            ls_we,
    input  logic            ls_dword,
    input  logic [AW-1:0]   ls_addr,
    input  logic [XLEN-1:0] ls_wdata,
    output logic            ls_stall,
    output logic [XLEN-1:0] ls_rdata,
    output logic            mem_en,
    output logic            mem_we,
    output logic            mem_dword,
    output logic [AW-1:0]   mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    input  logic [XLEN-1:0] mem_rdata
);
    localparam int EXT = AW - OFFW;

    amo_state_e      state_q, state_d;
    amo_dec_t        dec_in, dec_q;
    logic [AW-1:0]   addr_q;
    logic [XLEN-1:0] src_q, r0_q, new_q;
    logic [XLEN-1:0] res_src_q, res_r0_q;
    logic            wr_q, err_q;
    logic [XLEN-1:0] alu_new, alu_src, alu_r0;
    logic            alu_wr;
    logic            accept;

    amo_decode #(.IMMW(IMMW)) u_dec (
        .imm  (req_imm),
        .size (req_size),
        .dec  (dec_in)
    );

    amo_alu #(.XLEN(XLEN)) u_alu (
        .dec      (dec_q),
        .old_raw  (mem_rdata),
        .src      (src_q),
        .r0       (r0_q),
        .new_val  (alu_new),
        .do_write (alu_wr),
        .src_out  (alu_src),
        .r0_out   (alu_r0)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = dec_in.legal ? ST_READ : ST_DONE;
            ST_READ:   state_d = ST_MODIFY;
            ST_MODIFY: state_d = ST_WRITE;
            ST_WRITE:  state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operand and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_q     <= '0;
            addr_q    <= '0;
            src_q     <= '0;
            r0_q      <= '0;
            new_q     <= '0;
            wr_q      <= 1'b0;
            err_q     <= 1'b0;
            res_src_q <= '0;
            res_r0_q  <= '0;
        end else begin
            if (accept) begin
                dec_q     <= dec_in;
                addr_q    <= req_base + {{EXT{req_offset[OFFW-1]}}, req_offset};
                src_q     <= req_src;
                r0_q      <= req_r0;
                err_q     <= !dec_in.legal;
                res_src_q <= req_src;
                res_r0_q  <= req_r0;
                wr_q      <= 1'b0;
            end
            if (state_q == ST_MODIFY) begin
                new_q     <= alu_new;
                wr_q      <= alu_wr;
                res_src_q <= alu_src;
                res_r0_q  <= alu_r0;
            end
        end
    end

    // outputs and memory port steering
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_DONE);
        err       = done && err_q;
        res_src   = res_src_q;
        res_r0    = res_r0_q;
        ls_stall  = busy;
        ls_rdata  = mem_rdata;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_dword = dec_q.dword;
        mem_addr  = addr_q;
        mem_wdata = new_q;
        unique case (state_q)
            ST_IDLE: begin
                mem_en    = ls_valid;
                mem_we    = ls_we;
                mem_dword = ls_dword;
                mem_addr  = ls_addr;
                mem_wdata = ls_wdata;
            end
            ST_READ: begin
                mem_en = 1'b1;
            end
            ST_WRITE: begin
                mem_en = wr_q;
                mem_we = wr_q;
            end
            ST_MODIFY, ST_DONE: begin
                mem_en = 1'b0;
            end
            default: mem_en = 1'b0;
        endcase
    end

endmodule

// File: rtl/amo_seq_chk.sv
module amo_seq_chk #(
    parameter int XLEN = 64,
    parameter int AW   = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [1:0]      req_size,
    input logic            busy,
    input logic            done,
    input logic            err,
    input logic            mem_en,
    input logic            mem_we,
    input logic            mem_dword,
    input logic [AW-1:0]   mem_addr,
    input logic [XLEN-1:0] mem_wdata
);
    logic touched;

    always_ff @(posedge clk) begin
        if (!rst_n)                    touched <= 1'b0;
        else if (req_valid && !busy)   touched <= 1'b0;
        else if (busy && mem_en)       touched <= 1'b1;
    end

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> busy); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8
    AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy); // R8
    AST_BAD_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy && (req_size == 2'b01 || req_size == 2'b10)) |=> (done && err)); // R1
    AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> !touched); // R7
    AST_SAME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_en && mem_we) |-> ($past(mem_addr, 2) == mem_addr && $past(mem_en && !mem_we, 2))); // R2
    AST_WORD_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && mem_en && mem_we && !mem_dword) |-> (mem_wdata[XLEN-1:XLEN/2] == '0)); // R10

endmodule

bind amo_seq_unit amo_seq_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_size  (req_size),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .mem_dword (mem_dword),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
);

// File: tb/amo_seq_unit_tb.sv
module amo_seq_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [63:0] req_base = '0;
    logic [15:0] req_offset = '0;
    logic [63:0] req_src = '0;
    logic [63:0] req_r0 = '0;
    logic [1:0]  req_size = '0;
    logic [7:0]  req_imm = '0;
    logic        busy, done, err;
    logic [63:0] res_src, res_r0;
    logic        ls_valid = 1'b0;
    logic        ls_we = 1'b0;
    logic        ls_dword = 1'b1;
    logic [63:0] ls_addr = '0;
    logic [63:0] ls_wdata = '0;
    logic        ls_stall;
    logic [63:0] ls_rdata;
    logic        mem_en, mem_we, mem_dword;
    logic [63:0] mem_addr, mem_wdata;
    logic [63:0] mem_rdata;

    logic [63:0] mem [16];

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    amo_seq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_offset(req_offset), .req_src(req_src), .req_r0(req_r0),
        .req_size(req_size), .req_imm(req_imm), .busy(busy), .done(done),
        .err(err), .res_src(res_src), .res_r0(res_r0), .ls_valid(ls_valid),
        .ls_we(ls_we), .ls_dword(ls_dword), .ls_addr(ls_addr),
        .ls_wdata(ls_wdata), .ls_stall(ls_stall), .ls_rdata(ls_rdata),
        .mem_en(mem_en), .mem_we(mem_we), .mem_dword(mem_dword),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // single-port synchronous memory, 16 double words
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) mem[i] <= 64'h0;
            mem_rdata <= '0;
        end else if (mem_en) begin
            if (mem_we) begin
                if (mem_dword)        mem[mem_addr[6:3]] <= mem_wdata;
                else if (mem_addr[2]) mem[mem_addr[6:3]][63:32] <= mem_wdata[31:0];
                else                  mem[mem_addr[6:3]][31:0]  <= mem_wdata[31:0];
            end else begin
                if (mem_dword)        mem_rdata <= mem[mem_addr[6:3]];
                else if (mem_addr[2]) mem_rdata <= {32'h0, mem[mem_addr[6:3]][63:32]};
                else                  mem_rdata <= {32'h0, mem[mem_addr[6:3]][31:0]};
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic ls_access(input bit we, input logic [63:0] a, input logic [63:0] d);
        @(negedge clk);
        ls_valid = 1'b1; ls_we = we; ls_dword = 1'b1; ls_addr = a; ls_wdata = d;
        @(posedge clk);
        @(negedge clk);
        ls_valid = 1'b0; ls_we = 1'b0;
    endtask

    // expected-result model from the requirements
    task automatic run_op(input logic [63:0] tgt, input logic [15:0] off,
                          input logic [63:0] src, input logic [63:0] r0,
                          input logic [1:0] size, input logic [7:0] imm,
                          input bit inject);
        logic [63:0] base, old, s, nv, entry, exp_src, exp_r0, exp_entry;
        bit legal, dw, fetch, wr, cas;
        int cycles, exp_lat;
        base  = tgt - {{48{off[15]}}, off};
        dw    = (size == 2'b11);
        fetch = imm[0];
        cas   = 1'b0;
        entry = mem[tgt[6:3]];
        old   = dw ? entry : (tgt[2] ? {32'h0, entry[63:32]} : {32'h0, entry[31:0]});
        s     = dw ? src : {32'h0, src[31:0]};
        legal = (size == 2'b00 || size == 2'b11);
        nv    = '0;
        case (imm)
            8'h00, 8'h01: nv = old + s;
            8'h40, 8'h41: nv = old | s;
            8'h50, 8'h51: nv = old & s;
            8'hA0, 8'hA1: nv = old ^ s;
            8'hE1:        nv = s;
            8'hF1: begin  nv = s; cas = 1'b1; end
            default:      legal = 1'b0;
        endcase
        if (!dw) nv = {32'h0, nv[31:0]};
        wr = legal && (!cas || (dw ? (old == r0) : (old[31:0] == r0[31:0])));
        exp_src = (legal && fetch && !cas) ? old : src;
        exp_r0  = (legal && cas) ? old : r0;
        exp_entry = entry;
        if (wr) begin
            if (dw)          exp_entry = nv;
            else if (tgt[2]) exp_entry[63:32] = nv[31:0];
            else             exp_entry[31:0]  = nv[31:0];
        end
        exp_lat = legal ? 4 : 1;

        @(negedge clk);
        req_valid = 1'b1; req_base = base; req_offset = off; req_src = src;
        req_r0 = r0; req_size = size; req_imm = imm;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cycles = 1;
        if (inject && legal) begin
            ls_valid = 1'b1; ls_we = 1'b1; ls_dword = 1'b1;
            ls_addr = tgt; ls_wdata = ~entry;
            chk(ls_stall == 1'b1, "R9 stall", {63'h0, ls_stall}, 64'h1);
        end
        while (!done && cycles < 10) begin
            @(negedge clk);
            cycles++;
        end
        ls_valid = 1'b0; ls_we = 1'b0;
        chk(cycles == exp_lat, "R8 latency", 64'(cycles), 64'(exp_lat));
        chk(err == !legal, (size == 2'b01 || size == 2'b10) ? "R1 err" : "R7 err",
            {63'h0, err}, {63'h0, !legal});
        chk(res_src == exp_src, cas ? "R6 src" : (imm == 8'hE1 ? "R5 src" : "R4 src"),
            res_src, exp_src);
        chk(res_r0 == exp_r0, "R6 r0", res_r0, exp_r0);
        chk(mem[tgt[6:3]] == exp_entry,
            cas ? "R6 mem" : (dw ? "R3 R2 mem" : "R10 R3 mem"),
            mem[tgt[6:3]], exp_entry);
    endtask

    function automatic logic [63:0] rand_tgt(input bit dw);
        logic [63:0] t;
        t = {57'h0, 4'($urandom), 3'b000};
        if (!dw) t[2] = 1'($urandom);
        return t;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] imms [12];
        imms = '{8'h00, 8'h01, 8'h40, 8'h41, 8'h50, 8'h51,
                 8'hA0, 8'hA1, 8'hE1, 8'hF1, 8'hE0, 8'h33};
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0 && mem_en == 1'b0, "R8 reset",
            {61'h0, busy, done, mem_en}, 64'h0);
        rst_n = 1'b1;

        // preload through the load/store port, check a readback (R9)
        for (int i = 0; i < 16; i++)
            ls_access(1'b1, 64'(i * 8), {$urandom, $urandom});
        ls_access(1'b0, 64'd40, 64'h0);
        chk(ls_rdata == mem[5], "R9 load", ls_rdata, mem[5]);

        // directed corner cases
        ls_access(1'b1, 64'd0, 64'h1234_5678_FFFF_FFFF);
        run_op(64'd0, 16'h0000, 64'h0000_0000_0000_0001, 64'h0, 2'b00, 8'h01, 1'b0); // R3 wrap, R4
        run_op(64'd8, 16'hFFF8, 64'hA5A5, 64'h0, 2'b11, 8'h00, 1'b0);                // R2 negative offset
        ls_access(1'b1, 64'd16, 64'hDEAD_BEEF_0000_0042);
        run_op(64'd20, 16'h0004, 64'h77, 64'hFFFF_FFFF_DEAD_BEEF, 2'b00, 8'hF1, 1'b1); // R6 word match
        run_op(64'd24, 16'h0000, 64'h99, 64'h1, 2'b11, 8'hF1, 1'b0);                  // R6 mismatch
        run_op(64'd32, 16'h0000, 64'h5, 64'h6, 2'b01, 8'h00, 1'b0);                   // R1 half
        run_op(64'd32, 16'h0000, 64'h5, 64'h6, 2'b10, 8'h00, 1'b0);                   // R1 byte
        run_op(64'd32, 16'h0000, 64'h5, 64'h6, 2'b11, 8'hF0, 1'b0);                   // R7
        run_op(64'd40, 16'h0010, 64'h1111_2222_3333_4444, 64'h0, 2'b11, 8'hE1, 1'b1); // R5

        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [1:0]  sz;
            logic [7:0]  op;
            logic [63:0] t, r0v;
            int pick;
            pick = int'($urandom % 10);
            sz   = (pick == 0) ? 2'($urandom % 2 + 1) : (pick < 5 ? 2'b00 : 2'b11);
            op   = imms[$urandom % 12];
            t    = rand_tgt(sz == 2'b11);
            r0v  = {$urandom, $urandom};
            if (op == 8'hF1 && ($urandom % 2) == 0) begin
                if (sz == 2'b11) r0v = mem[t[6:3]];
                else r0v = {$urandom, (t[2] ? mem[t[6:3]][63:32] : mem[t[6:3]][31:0])};
            end
            run_op(t, 16'($urandom), {$urandom, $urandom}, r0v, sz, op, 1'($urandom));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule